// File: doc/BRIEF.md
# Interrupt Controller Mode and Access Unit

This unit sits in front of a local interrupt controller's register file. It owns the controller's configuration word: a global enable, an extended-mode flag and a page-aligned base address. Every incoming register access is decoded against that word. The unit reports the current operating mode and accepts writes that change it. A write that would break the allowed mode sequence is refused: the stored word stays as it was, and an error strobe is raised.

Register accesses reach the unit in two forms. In legacy mode an access carries a full memory address, which must fall inside the 4 KB window at the base. Its offset within the window must be a multiple of 16. In extended mode an access carries a register index instead. The index must lie in a 256-entry range that starts at a fixed index base. Both forms are reduced to the same 8-bit slot number and to the equivalent extended-mode index. Any access that is not allowed in the current mode is returned with a fault code in place of a slot. The interrupt delivery logic behind the registers is outside this unit.

Top module: `irqc_mode_unit`

## Requirements
- R1: After reset the unit is enabled (`mode_valid`=1), in legacy mode (`mode_ext`=0), with `base_addr`=0xFEE00000, `cfg_err`=0 and `rsp_valid`=0.
- R2: A configuration write that is accepted updates the enable bit, the extended bit and the base on the next clock edge. `mode_valid` then shows the enable bit and `mode_ext` the extended bit, and `cfg_err` stays 0.
- R3: A configuration write whose base has any of bits [11:0] set is rejected. A rejected write of any kind leaves all three fields unchanged and raises `cfg_err` for exactly the one cycle after the write.
- R4: A write with the extended bit set and the enable bit clear is rejected, whatever the current state.
- R5: While in extended mode, a write of enable=1, extended=0 is rejected. The only way out of extended mode is a write of enable=0, extended=0, which reaches the disabled state. A later enable=1, extended=0 write then lands in legacy mode.
- R6: From legacy or disabled state, a write of enable=1, extended=1 with an aligned base enters extended mode.
- R7: Each access gets a fault code, with 0 meaning no fault, 1 the unit is disabled, 2 misaligned offset, 3 outside the window or index range, and 4 forbidden in this mode. While disabled, every access returns fault 1.
- R8: In legacy mode, an address whose bits [31:12] differ from the base returns fault 3. If those bits match but bits [3:0] are nonzero, the access returns fault 2. Otherwise the slot is address bits [11:4] and `rsp_index` is 0x800 plus the slot. Slots 0x0E and 0x31 are allowed in legacy mode.
- R9: In extended mode, an address whose bits [31:8] are not 0x008 returns fault 3. Otherwise the slot is address bits [7:0] and `rsp_index` equals the address.
- R10: In extended mode, slot 0x0E (destination format) and slot 0x31 (upper half of the command register) return fault 4.
- R11: Each cycle with `acc_valid` high produces `rsp_valid` high on the following cycle, with `rsp_write` echoing `acc_write`. When the fault is nonzero, `rsp_slot` and `rsp_index` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_enable | input | 1 | Enable bit to write |
| cfg_wr_ext | input | 1 | Extended-mode bit to write |
| cfg_wr_base | input | 32 | Base address to write (must be 4 KB aligned) |
| mode_valid | output | 1 | Global enable bit; mode is only meaningful while set |
| mode_ext | output | 1 | 1 = extended mode, 0 = legacy mode |
| base_addr | output | 32 | Stored base address |
| cfg_err | output | 1 | One-cycle strobe for a rejected configuration write |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 32 | Memory address (legacy) or register index (extended) |
| rsp_valid | output | 1 | Decoded access result valid |
| rsp_write | output | 1 | Echo of the access direction |
| rsp_fault | output | 3 | Fault code (see R7) |
| rsp_slot | output | 8 | Register slot number |
| rsp_index | output | 32 | Equivalent extended-mode register index |

## Verification
The hardest state to reach from the ports is extended mode followed by a direct return request. This needs a legal entry into extended mode first, then the illegal enable=1, extended=0 write, and then the two-step exit. The bench drives each start state (legacy, extended, disabled) from a fresh reset through legal writes. It then applies every enable/extended combination, with aligned and misaligned bases, so each transition is seen from each state. The access decode is swept across the whole legacy window in 4-byte steps and across the extended index range plus its edges, with each expected fault worked out in the bench.

// File: rtl/irqc_mode_pkg.sv
package irqc_mode_pkg;

    // Fault codes carried with every decoded access
    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_OFF    = 3'd1,
        FLT_ALIGN  = 3'd2,
        FLT_RANGE  = 3'd3,
        FLT_BANNED = 3'd4
    } flt_e;

    // Enable / extended pair as stored
    typedef struct packed {
        logic en;
        logic ext;
    } mode_t;

endpackage

// File: rtl/irqc_mode_reg.sv
module irqc_mode_reg
    import irqc_mode_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter int              PAGE_BITS  = 12,
    parameter logic [63:0]     RESET_BASE = 64'hFEE0_0000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_enable,
    input  logic                      wr_ext,
    input  logic [ADDR_W-1:0]         wr_base,
    output logic                      en_o,
    output logic                      ext_o,
    output logic [ADDR_W-PAGE_BITS-1:0] page_o,
    output logic                      err_o
);
    localparam int PAGE_W = ADDR_W - PAGE_BITS;
    localparam logic [ADDR_W-1:0] RST_ADDR = RESET_BASE[ADDR_W-1:0];

    typedef struct packed {
        mode_t             mode;
        logic [PAGE_W-1:0] page;
        logic              err;
    } st_t;

    st_t st_d, st_q;

    logic bad_align, bad_orphan, bad_exit;

    always_comb begin
        st_d       = st_q;
        st_d.err   = 1'b0;
        bad_align  = |wr_base[PAGE_BITS-1:0];
        bad_orphan = wr_ext & ~wr_enable;
        bad_exit   = st_q.mode.en & st_q.mode.ext & wr_enable & ~wr_ext;
        if (wr_en) begin
            if (bad_align || bad_orphan || bad_exit) begin
                st_d.err = 1'b1;
            end else begin
                st_d.mode.en  = wr_enable;
                st_d.mode.ext = wr_ext;
                st_d.page     = wr_base[ADDR_W-1:PAGE_BITS];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode.en  <= 1'b1;
            st_q.mode.ext <= 1'b0;
            st_q.page     <= RST_ADDR[ADDR_W-1:PAGE_BITS];
            st_q.err      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.mode.en;
    assign ext_o  = st_q.mode.ext;
    assign page_o = st_q.page;
    assign err_o  = st_q.err;

endmodule

// File: rtl/irqc_acc_decode.sv
module irqc_acc_decode
    import irqc_mode_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int SLOT_BITS = 4,
    parameter int IDX_BASE  = 'h800,
    parameter int N_BAN     = 2,
    parameter int BAN_LIST [N_BAN] = '{'h0E, 'h31}
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en_i,
    input  logic                          ext_i,
    input  logic [ADDR_W-PAGE_BITS-1:0]   page_i,
    input  logic                          acc_valid,
    input  logic                          acc_write,
    input  logic [ADDR_W-1:0]             acc_addr,
    output logic                          rsp_valid,
    output logic                          rsp_write,
    output logic [2:0]                    rsp_fault,
    output logic [PAGE_BITS-SLOT_BITS-1:0] rsp_slot,
    output logic [ADDR_W-1:0]             rsp_index
);
    localparam int IDX_W = PAGE_BITS - SLOT_BITS;
    localparam logic [ADDR_W-1:0] IDX_BASE_V = ADDR_W'(IDX_BASE);

    typedef struct packed {
        logic              vld;
        logic              wr;
        flt_e              flt;
        logic [IDX_W-1:0]  slot;
        logic [ADDR_W-1:0] index;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [IDX_W-1:0] slot_leg, slot_ext;
    logic             leg_in_win, leg_misal, ext_in_rng;
    logic [N_BAN-1:0] ban_hit;

    // One comparator per forbidden slot
    for (genvar gi = 0; gi < N_BAN; gi++) begin : g_ban
        assign ban_hit[gi] = (slot_ext == IDX_W'(BAN_LIST[gi]));
    end

    always_comb begin
        slot_leg   = acc_addr[PAGE_BITS-1:SLOT_BITS];
        slot_ext   = acc_addr[IDX_W-1:0];
        leg_in_win = (acc_addr[ADDR_W-1:PAGE_BITS] == page_i);
        leg_misal  = |acc_addr[SLOT_BITS-1:0];
        ext_in_rng = (acc_addr[ADDR_W-1:IDX_W] == IDX_BASE_V[ADDR_W-1:IDX_W]);

        rsp_d       = '0;
        rsp_d.vld   = acc_valid;
        rsp_d.wr    = acc_valid & acc_write;
        rsp_d.flt   = FLT_NONE;
        if (acc_valid) begin
            if (!en_i) begin
                rsp_d.flt = FLT_OFF;
            end else if (!ext_i) begin
                if (!leg_in_win)      rsp_d.flt = FLT_RANGE;
                else if (leg_misal)   rsp_d.flt = FLT_ALIGN;
                else                  rsp_d.slot = slot_leg;
            end else begin
                if (!ext_in_rng)      rsp_d.flt = FLT_RANGE;
                else if (|ban_hit)    rsp_d.flt = FLT_BANNED;
                else                  rsp_d.slot = slot_ext;
            end
            if (rsp_d.flt == FLT_NONE) begin
                rsp_d.index = IDX_BASE_V + ADDR_W'(rsp_d.slot);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_write = rsp_q.wr;
    assign rsp_fault = rsp_q.flt;
    assign rsp_slot  = rsp_q.slot;
    assign rsp_index = rsp_q.index;

endmodule

// File: rtl/irqc_mode_unit.sv
module irqc_mode_unit
    import irqc_mode_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          PAGE_BITS  = 12,
    parameter int          SLOT_BITS  = 4,
    parameter int          IDX_BASE   = 'h800,
    parameter logic [63:0] RESET_BASE = 64'hFEE0_0000,
    localparam int         IDX_W      = PAGE_BITS - SLOT_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_enable,
    input  logic              cfg_wr_ext,
    input  logic [ADDR_W-1:0] cfg_wr_base,
    output logic              mode_valid,
    output logic              mode_ext,
    output logic [ADDR_W-1:0] base_addr,
    output logic              cfg_err,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              rsp_valid,
    output logic              rsp_write,
    output logic [2:0]        rsp_fault,
    output logic [IDX_W-1:0]  rsp_slot,
    output logic [ADDR_W-1:0] rsp_index
);
    localparam int PAGE_W = ADDR_W - PAGE_BITS;

    logic              en_w, ext_w;
    logic [PAGE_W-1:0] page_w;

    irqc_mode_reg #(
        .ADDR_W     (ADDR_W),
        .PAGE_BITS  (PAGE_BITS),
        .RESET_BASE (RESET_BASE)
    ) mode_reg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_enable (cfg_wr_enable),
        .wr_ext    (cfg_wr_ext),
        .wr_base   (cfg_wr_base),
        .en_o      (en_w),
        .ext_o     (ext_w),
        .page_o    (page_w),
        .err_o     (cfg_err)
    );

    irqc_acc_decode #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS),
        .SLOT_BITS (SLOT_BITS),
        .IDX_BASE  (IDX_BASE)
    ) decode_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_w),
        .ext_i     (ext_w),
        .page_i    (page_w),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .rsp_valid (rsp_valid),
        .rsp_write (rsp_write),
        .rsp_fault (rsp_fault),
        .rsp_slot  (rsp_slot),
        .rsp_index (rsp_index)
    );

    assign mode_valid = en_w;
    assign mode_ext   = ext_w;
    assign base_addr  = {page_w, {PAGE_BITS{1'b0}}};

endmodule

// File: rtl/irqc_mode_unit_chk.sv
module irqc_mode_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic              mode_valid,
    input logic              mode_ext,
    input logic [ADDR_W-1:0] base_addr,
    input logic              cfg_err,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              rsp_valid,
    input logic [2:0]        rsp_fault,
    input logic [ADDR_W-1:0] rsp_index
);
    assert_reject_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (mode_valid == $past(mode_valid) && mode_ext == $past(mode_ext)
                     && base_addr == $past(base_addr)));

    assert_err_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(cfg_wr_en));

    assert_ext_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ext |-> mode_valid);

    assert_exit_via_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_ext) |-> !mode_valid);

    assert_off_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(mode_valid)) |-> rsp_fault == 3'd1);

    assert_ext_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 3'd0 && $past(mode_ext)) |-> rsp_index == $past(acc_addr));

    assert_banned_ext_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 3'd4) |-> $past(mode_ext));

    assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(acc_valid));

endmodule

bind irqc_mode_unit irqc_mode_unit_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_en  (cfg_wr_en),
    .mode_valid (mode_valid),
    .mode_ext   (mode_ext),
    .base_addr  (base_addr),
    .cfg_err    (cfg_err),
    .acc_valid  (acc_valid),
    .acc_addr   (acc_addr),
    .rsp_valid  (rsp_valid),
    .rsp_fault  (rsp_fault),
    .rsp_index  (rsp_index)
);

// File: tb/irqc_mode_unit_tb_top.sv
module irqc_mode_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0, cfg_wr_enable = 1'b0, cfg_wr_ext = 1'b0;
    logic [31:0] cfg_wr_base = '0;
    logic        mode_valid, mode_ext, cfg_err;
    logic [31:0] base_addr;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        rsp_valid, rsp_write;
    logic [2:0]  rsp_fault;
    logic [7:0]  rsp_slot;
    logic [31:0] rsp_index;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    // Bench-side model of the stored word
    logic        m_en, m_ext;
    logic [31:0] m_base;

    irqc_mode_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_enable(cfg_wr_enable), .cfg_wr_ext(cfg_wr_ext),
        .cfg_wr_base(cfg_wr_base),
        .mode_valid(mode_valid), .mode_ext(mode_ext), .base_addr(base_addr), .cfg_err(cfg_err),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_fault(rsp_fault),
        .rsp_slot(rsp_slot), .rsp_index(rsp_index)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_en = 1'b1; m_ext = 1'b0; m_base = 32'hFEE0_0000;
    endtask

    task automatic do_cfg(input logic we, input logic wx, input logic [31:0] b);
        logic  acc;
        string tag;
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_enable = we; cfg_wr_ext = wx; cfg_wr_base = b;
        if (|b[11:0])                      begin acc = 1'b0; tag = "R3"; end
        else if (wx && !we)                begin acc = 1'b0; tag = "R4"; end
        else if (m_en && m_ext && we && !wx) begin acc = 1'b0; tag = "R5"; end
        else begin
            acc = 1'b1;
            if (m_ext && !we)      tag = "R5";
            else if (!m_ext && wx) tag = "R6";
            else                   tag = "R2";
        end
        if (acc) begin m_en = we; m_ext = wx; m_base = b; end
        @(negedge clk);
        cfg_wr_en = 1'b0;
        chk(cfg_err == !acc,         {tag, " cfg_err"},  64'(cfg_err), 64'(!acc));
        chk(mode_valid == m_en,      {tag, " enable"},   64'(mode_valid), 64'(m_en));
        chk(mode_ext == m_ext,       {tag, " ext"},      64'(mode_ext), 64'(m_ext));
        chk(base_addr == m_base,     {tag, " base"},     64'(base_addr), 64'(m_base));
        @(negedge clk);
        chk(cfg_err == 1'b0,         "R3 pulse width",   64'(cfg_err), 64'd0);
    endtask

    task automatic do_acc(input logic [31:0] a, input logic w);
        logic [2:0]  ef;
        logic [7:0]  es;
        logic [31:0] ei;
        string       tag;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_addr = a;
        ef = 3'd0; es = 8'd0;
        if (!m_en) begin ef = 3'd1; tag = "R7"; end
        else if (!m_ext) begin
            tag = "R8";
            if (a[31:12] != m_base[31:12]) ef = 3'd3;
            else if (a[3:0] != 4'd0)       ef = 3'd2;
            else begin
                es = a[11:4];
                if (es == 8'h0E || es == 8'h31) tag = "R10";
            end
        end else begin
            tag = "R9";
            if (a[31:8] != 24'h000008) ef = 3'd3;
            else if (a[7:0] == 8'h0E || a[7:0] == 8'h31) begin ef = 3'd4; tag = "R10"; end
            else es = a[7:0];
        end
        ei = (ef == 3'd0) ? (32'h800 + 32'(es)) : 32'd0;
        @(negedge clk);
        acc_valid = 1'b0;
        chk(rsp_valid == 1'b1,   "R11 rsp_valid", 64'(rsp_valid), 64'd1);
        chk(rsp_write == w,      "R11 rsp_write", 64'(rsp_write), 64'(w));
        chk(rsp_fault == ef,     {tag, " fault"}, 64'(rsp_fault), 64'(ef));
        chk(rsp_slot == es,      {tag, " slot"},  64'(rsp_slot),  64'(es));
        chk(rsp_index == ei,     {tag, " index"}, 64'(rsp_index), 64'(ei));
    endtask

    task automatic goto_state(input int s);
        do_reset();
        if (s == 1) do_cfg(1'b1, 1'b1, 32'hFEE0_0000);
        if (s == 2) do_cfg(1'b0, 1'b0, 32'hFEE0_0000);
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        chk(mode_valid == 1'b1,         "R1 enable", 64'(mode_valid), 64'd1);
        chk(mode_ext == 1'b0,           "R1 ext",    64'(mode_ext), 64'd0);
        chk(base_addr == 32'hFEE0_0000, "R1 base",   64'(base_addr), 64'hFEE0_0000);
        chk(cfg_err == 1'b0,            "R1 cfg_err", 64'(cfg_err), 64'd0);
        chk(rsp_valid == 1'b0,          "R1 rsp_valid", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        chk(rsp_valid == 1'b0,          "R11 idle", 64'(rsp_valid), 64'd0);

        // Legacy window sweep in 4-byte steps, plus the edges outside it
        for (int k = 0; k < 1024; k++) do_acc(32'hFEE0_0000 + 32'(k*4), k[0]);
        do_acc(32'hFEDF_FFF0, 1'b0);
        do_acc(32'hFEE0_1000, 1'b1);
        do_acc(32'h0000_0830, 1'b0);

        // Relocate the base, then sweep a sample of the new window
        do_cfg(1'b1, 1'b0, 32'h1234_5000);
        for (int k = 0; k < 64; k++) do_acc(32'h1234_5000 + 32'(k*68), 1'b0);
        do_acc(32'hFEE0_0010, 1'b0);

        // Enter extended mode and sweep the index range and its edges
        do_cfg(1'b1, 1'b1, 32'h1234_5000);
        for (int k = 'h7F0; k < 'h910; k++) do_acc(32'(k), k[1]);
        do_acc(32'h1234_5010, 1'b0);

        // Two-step exit from extended mode
        do_cfg(1'b1, 1'b0, 32'h1234_5000);
        do_acc(32'h0000_0802, 1'b0);
        do_cfg(1'b0, 1'b0, 32'h1234_5000);
        do_acc(32'h1234_5020, 1'b1);
        do_acc(32'h0000_0820, 1'b0);
        do_cfg(1'b1, 1'b0, 32'h1234_5000);
        do_acc(32'h1234_5020, 1'b1);

        // Every write from every start state, aligned and misaligned
        for (int s = 0; s < 3; s++) begin
            for (int v = 0; v < 8; v++) begin
                goto_state(s);
                do_cfg(v[0], v[1], v[2] ? 32'hC000_0040 : 32'hC000_0000 + 32'(s*'h1000));
                do_acc(32'h0000_0880, 1'b0);
                do_acc(32'hC000_0000 + 32'(s*'h1000) + 32'h0E0, 1'b1);
            end
        end

        finish_run();
    end

endmodule